// File: doc/BRIEF.md
# Mailbox Interrupt Flags for a Two-Port Memory

This block produces one active-low interrupt flag for each port of a shared two-port memory. Two words at the top of the address space act as mailboxes. A port that writes the other port's mailbox word raises that port's flag. The receiving port clears its flag by reading the same word. The mailbox words stay ordinary storage in the memory array, and the array itself is outside this block. The block only watches the access signals that each port already presents to the array.

Each port presents a select, a write strobe, a read (output-enable) strobe, an address and the arbiter's busy indication for that port. All of these are active high and are sampled on the rising clock edge. The left port's mailbox is the address with all bits set except bit 0, which is 0xFFE for 12 address bits. The right port's mailbox is the all-ones address, 0xFFF. A busy port cannot change a flag through its own access. A parameter removes the function entirely, and both flags then stay inactive.

Top module: `mbx_irq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) drives both `lp_irq_n` and `rp_irq_n` high at that edge.
- R2: When the right port has `rp_sel` and `rp_wr` high with `rp_addr` equal to all-ones minus one, `lp_irq_n` goes low at that edge.
- R3: When the left port has `lp_sel` and `lp_rd` high with `lp_addr` equal to all-ones minus one, `lp_irq_n` goes high at that edge. The value of `lp_wr` does not matter.
- R4: When the left port has `lp_sel` and `lp_wr` high with `lp_addr` equal to all-ones, `rp_irq_n` goes low at that edge.
- R5: When the right port has `rp_sel` and `rp_rd` high with `rp_addr` equal to all-ones, `rp_irq_n` goes high at that edge. The value of `rp_wr` does not matter.
- R6: While the writing port's busy input is high, its mailbox write leaves the other port's flag unchanged.
- R7: While the reading port's busy input is high, its mailbox read leaves its own flag unchanged.
- R8: If a set and a clear of the same flag fall on the same edge, the flag goes (or stays) low.
- R9: In every other case a flag holds its value. This covers accesses to any other address, strobes without select, a read of the other port's mailbox, and a port writing its own mailbox without its read strobe.
- R10: With `INT_EN` = 0, both flags remain high whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lp_sel | input | 1 | Left port access select |
| lp_wr | input | 1 | Left port write strobe |
| lp_rd | input | 1 | Left port read (output-enable) strobe |
| lp_busy | input | 1 | Arbiter busy for the left port |
| lp_addr | input | ADDR_W | Left port word address |
| rp_sel | input | 1 | Right port access select |
| rp_wr | input | 1 | Right port write strobe |
| rp_rd | input | 1 | Right port read (output-enable) strobe |
| rp_busy | input | 1 | Arbiter busy for the right port |
| rp_addr | input | ADDR_W | Right port word address |
| lp_irq_n | output | 1 | Left port interrupt, active low |
| rp_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The bench builds the block with `ADDR_W` = 4. The two mailboxes are then words 14 and 15 of a 16-word space, so a non-mailbox address is reached cheaply. At this size every combination of the eight control strobes on both ports can be crossed with each port aiming at either mailbox or at a plain word, from whatever flag state the previous vector left. A second instance with `INT_EN` = 0 receives the same stimulus and shows that the disabled variant keeps both flags high.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int NPORT = 2;
  localparam int PORT_L = 0;
  localparam int PORT_R = 1;

  // index of the port on the other side
  function automatic int peer_of(input int p);
    return (p == PORT_L) ? PORT_R : PORT_L;
  endfunction

  // distance of a port's mailbox word below the all-ones address
  function automatic int mbx_offset(input int p);
    return (p == PORT_L) ? 1 : 0;
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MBX = '1,
  parameter bit ON_WRITE = 1'b1
) (
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic strobe;

  generate
    if (ON_WRITE) begin : g_wr
      // a write-side hit needs the write strobe; the read strobe is unused
      logic unused_rd;
      assign unused_rd = rd;
      assign strobe = wr;
    end else begin : g_rd
      // a read-side hit needs the output-enable; the write strobe is ignored
      logic unused_wr;
      assign unused_wr = wr;
      assign strobe = rd;
    end
  endgenerate

  assign hit = sel & strobe & ~busy & (addr == MBX);
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  output logic flag_n
);
  always_ff @(posedge clk) begin
    if (rst)          flag_n <= 1'b1;
    else if (set_req) flag_n <= 1'b0;
    else if (clr_req) flag_n <= 1'b1;
  end

  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_req |=> !flag_n);
  a_r3_clear_raises: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !set_req) |=> flag_n);
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!set_req && !clr_req) |=> $stable(flag_n));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter bit INT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lp_sel,
  input  logic              lp_wr,
  input  logic              lp_rd,
  input  logic              lp_busy,
  input  logic [ADDR_W-1:0] lp_addr,
  input  logic              rp_sel,
  input  logic              rp_wr,
  input  logic              rp_rd,
  input  logic              rp_busy,
  input  logic [ADDR_W-1:0] rp_addr,
  output logic              lp_irq_n,
  output logic              rp_irq_n
);
  localparam logic [ADDR_W-1:0] ALL1 = '1;
  localparam logic [ADDR_W-1:0] LMBX = ALL1 - ADDR_W'(mbx_offset(PORT_L));
  localparam logic [ADDR_W-1:0] RMBX = ALL1 - ADDR_W'(mbx_offset(PORT_R));

  logic              sel_a  [NPORT];
  logic              wr_a   [NPORT];
  logic              rd_a   [NPORT];
  logic              busy_a [NPORT];
  logic [ADDR_W-1:0] addr_a [NPORT];
  logic              irq_n_a[NPORT];

  assign sel_a[PORT_L]  = lp_sel;
  assign wr_a[PORT_L]   = lp_wr;
  assign rd_a[PORT_L]   = lp_rd;
  assign busy_a[PORT_L] = lp_busy;
  assign addr_a[PORT_L] = lp_addr;
  assign sel_a[PORT_R]  = rp_sel;
  assign wr_a[PORT_R]   = rp_wr;
  assign rd_a[PORT_R]   = rp_rd;
  assign busy_a[PORT_R] = rp_busy;
  assign addr_a[PORT_R] = rp_addr;

  generate
    if (INT_EN) begin : g_on
      for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int Q = peer_of(p);
        localparam logic [ADDR_W-1:0] MBX = ALL1 - ADDR_W'(mbx_offset(p));
        logic set_hit;
        logic clr_hit;

        // the peer writes this port's mailbox word
        mbx_decode #(.ADDR_W(ADDR_W), .MBX(MBX), .ON_WRITE(1'b1)) u_set (
          .sel(sel_a[Q]), .wr(wr_a[Q]), .rd(rd_a[Q]), .busy(busy_a[Q]),
          .addr(addr_a[Q]), .hit(set_hit)
        );
        // this port reads its own mailbox word
        mbx_decode #(.ADDR_W(ADDR_W), .MBX(MBX), .ON_WRITE(1'b0)) u_clr (
          .sel(sel_a[p]), .wr(wr_a[p]), .rd(rd_a[p]), .busy(busy_a[p]),
          .addr(addr_a[p]), .hit(clr_hit)
        );
        irq_flag_reg u_flag (
          .clk(clk), .rst(rst), .set_req(set_hit), .clr_req(clr_hit),
          .flag_n(irq_n_a[p])
        );
      end

      a_r2_right_write_sets_left: assert property (@(posedge clk) disable iff (rst)
        (rp_sel && rp_wr && !rp_busy && rp_addr == LMBX) |=> !lp_irq_n);
      a_r4_left_write_sets_right: assert property (@(posedge clk) disable iff (rst)
        (lp_sel && lp_wr && !lp_busy && lp_addr == RMBX) |=> !rp_irq_n);
      a_r5_right_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rp_sel && rp_rd && !rp_busy && rp_addr == RMBX &&
         !(lp_sel && lp_wr && !lp_busy && lp_addr == RMBX)) |=> rp_irq_n);
    end else begin : g_off
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst, lp_sel, lp_wr, lp_rd, lp_busy, lp_addr,
                               rp_sel, rp_wr, rp_rd, rp_busy, rp_addr};
      for (genvar p = 0; p < NPORT; p++) begin : g_tie
        assign irq_n_a[p] = 1'b1;
      end
    end
  endgenerate

  assign lp_irq_n = irq_n_a[PORT_L];
  assign rp_irq_n = irq_n_a[PORT_R];

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (lp_irq_n && rp_irq_n));
  a_r6_busy_blocks_left_set: assert property (@(posedge clk) disable iff (rst)
    (rp_busy && lp_irq_n) |=> lp_irq_n);
  a_r6_busy_blocks_right_set: assert property (@(posedge clk) disable iff (rst)
    (lp_busy && rp_irq_n) |=> rp_irq_n);
  a_r7_busy_blocks_left_clear: assert property (@(posedge clk) disable iff (rst)
    (lp_busy && !lp_irq_n) |=> !lp_irq_n);
  a_r7_busy_blocks_right_clear: assert property (@(posedge clk) disable iff (rst)
    (rp_busy && !rp_irq_n) |=> !rp_irq_n);
endmodule

// File: tb/sim_mbx_irq.sv
module sim_mbx_irq;
  localparam int AW = 4;
  localparam logic [AW-1:0] LM = 4'd14;
  localparam logic [AW-1:0] RM = 4'd15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lsel = 0, lwr = 0, lrd = 0, lbusy = 0;
  logic rsel = 0, rwr = 0, rrd = 0, rbusy = 0;
  logic [AW-1:0] laddr = '0, raddr = '0;
  logic lirq, rirq, dl, dr;
  logic exp_l = 1'b1, exp_r = 1'b1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbx_irq #(.ADDR_W(AW), .INT_EN(1'b1)) u0 (
    .clk(clk), .rst(rst),
    .lp_sel(lsel), .lp_wr(lwr), .lp_rd(lrd), .lp_busy(lbusy), .lp_addr(laddr),
    .rp_sel(rsel), .rp_wr(rwr), .rp_rd(rrd), .rp_busy(rbusy), .rp_addr(raddr),
    .lp_irq_n(lirq), .rp_irq_n(rirq));

  mbx_irq #(.ADDR_W(AW), .INT_EN(1'b0)) u1 (
    .clk(clk), .rst(rst),
    .lp_sel(lsel), .lp_wr(lwr), .lp_rd(lrd), .lp_busy(lbusy), .lp_addr(laddr),
    .rp_sel(rsel), .rp_wr(rwr), .rp_rd(rrd), .rp_busy(rbusy), .rp_addr(raddr),
    .lp_irq_n(dl), .rp_irq_n(dr));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // ctl = {busy, rd, wr, sel}; apply on the falling edge, update model, sample after rising edge
  task automatic drive(input logic [3:0] lc, input logic [AW-1:0] la,
                       input logic [3:0] rc, input logic [AW-1:0] ra, input logic r);
    logic sl, cl, sr, cr;
    @(negedge clk);
    {lbusy, lrd, lwr, lsel} = lc; laddr = la;
    {rbusy, rrd, rwr, rsel} = rc; raddr = ra;
    rst = r;
    sl = rc[0] & rc[1] & ~rc[3] & (ra == LM);
    cl = lc[0] & lc[2] & ~lc[3] & (la == LM);
    sr = lc[0] & lc[1] & ~lc[3] & (la == RM);
    cr = rc[0] & rc[2] & ~rc[3] & (ra == RM);
    if (r) begin exp_l = 1'b1; exp_r = 1'b1; end
    else begin
      exp_l = sl ? 1'b0 : (cl ? 1'b1 : exp_l);
      exp_r = sr ? 1'b0 : (cr ? 1'b1 : exp_r);
    end
    @(posedge clk); #1;
  endtask

  function automatic logic [AW-1:0] pick(input int k, input int i);
    return (k == 0) ? LM : (k == 1) ? RM : AW'(i % 14);
  endfunction

  initial begin
    drive(4'h0, '0, 4'h0, '0, 1'b1);
    chk("R1 left after reset", lirq, 1'b1);
    chk("R1 right after reset", rirq, 1'b1);
    drive(4'h0, '0, 4'h3, LM, 1'b0);          // right writes left mailbox
    chk("R2 left set", lirq, 1'b0);
    chk("R2 right untouched", rirq, 1'b1);
    drive(4'h3, LM, 4'h0, '0, 1'b0);          // left writes own mailbox, no read
    chk("R9 write without read keeps", lirq, 1'b0);
    drive(4'hF, LM, 4'h0, '0, 1'b0);          // busy read
    chk("R7 busy read keeps", lirq, 1'b0);
    drive(4'h7, LM, 4'h0, '0, 1'b0);          // read with write high
    chk("R3 left clear", lirq, 1'b1);
    drive(4'hB, RM, 4'h0, '0, 1'b0);          // busy write
    chk("R6 busy write no set", rirq, 1'b1);
    drive(4'h3, RM, 4'h0, '0, 1'b0);
    chk("R4 right set", rirq, 1'b0);
    drive(4'h0, '0, 4'h4, RM, 1'b0);          // read strobe without select
    chk("R9 no select keeps", rirq, 1'b0);
    drive(4'h0, '0, 4'h5, LM, 1'b0);          // right reads the left mailbox
    chk("R9 peer mailbox read keeps", rirq, 1'b0);
    drive(4'h3, RM, 4'h5, RM, 1'b0);          // set and clear together
    chk("R8 set wins", rirq, 1'b0);
    drive(4'h0, '0, 4'h7, RM, 1'b0);
    chk("R5 right clear", rirq, 1'b1);
    drive(4'h0, '0, 4'h3, 4'd13, 1'b0);
    chk("R9 plain address keeps", lirq, 1'b1);

    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 3; j++) begin
        for (int k = 0; k < 3; k++) begin
          drive(i[3:0], pick(j, i), i[7:4], pick(k, i + 5), 1'b0);
          chk("R9 sweep left", lirq, exp_l);
          chk("R9 sweep right", rirq, exp_r);
          chk("R10 disabled left", dl, 1'b1);
          chk("R10 disabled right", dr, 1'b1);
        end
      end
    end

    drive(4'h3, RM, 4'h3, LM, 1'b0);
    chk("R2 set before reset", lirq, 1'b0);
    drive(4'h3, RM, 4'h3, LM, 1'b1);          // reset beats a set
    chk("R1 reset left", lirq, 1'b1);
    chk("R1 reset right", rirq, 1'b1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule